// File: doc/BRIEF.md
# Event Monitor Capture Buffer

This block listens to a 16-bit readout stream and keeps a copy of one event in a 256-word single-port RAM. A word is qualified by an active-low data-valid strobe. A capture trigger, accepted only while an enable bit is set, clears the address counter to zero and arms the buffer. Each valid word that follows is stored at the counter address, and the counter then steps forward. When the stream goes quiet for a programmable number of clock cycles, the event is taken to be complete. The buffer then locks until the next accepted trigger.

Software reads the event back through a small register interface. It can read the address counter at any time and load any value into it. A data-read request returns the word at the counter address one cycle later, and the counter advances. Stored words stay in place until a later capture overwrites them, so an event can be read more than once. A full event is 152 words.

The RAM has a single port. A capture write therefore always wins the RAM in its cycle, and a read requested in that cycle is carried out in the next free cycle. The counter wraps from 255 to 0. With the default parameters the idle timeout is 125 cycles, which is 1000 ns at a 125 MHz clock.

Top module: `evmon_capture`

## Requirements
- R1: After reset, `cnt_q` is 0, `armed` is 0 and `rd_valid` is 0.
- R2: `cap_trig` high with `cap_en` high sets `cnt_q` to 0 and `armed` to 1 at the next edge. `cap_trig` with `cap_en` low changes neither.
- R3: While `armed` is 1, each cycle with `snoop_dv_n` low writes `snoop_data` to the RAM at `cnt_q`, and `cnt_q` then increments by one.
- R4: `armed` falls after exactly `IDLE_CYCLES` consecutive cycles without a write. The count starts at the arming edge or the last write. While `armed` is 0, `snoop_dv_n` low neither writes the RAM nor moves `cnt_q`.
- R5: `cnt_ld` high loads `cnt_ld_val` into `cnt_q` at the next edge, and `cnt_q` can be observed at any time. An accepted trigger takes precedence over a load.
- R6: A cycle with `rd_req` high and no capture write reads the RAM word at `cnt_q`. At the next edge `rd_valid` is 1 for one cycle with that word on `rd_data`, and `cnt_q` increments.
- R7: If a capture write and `rd_req` fall in the same cycle, the write is performed first. `rd_valid` stays 0 at the next edge, and the read is served one cycle later at the incremented address.
- R8: Stored words are kept until overwritten. Reloading the counter and reading again returns the same data.
- R9: `cnt_q` wraps from 255 to 0 on a write increment or a read increment.
- R10: An accepted trigger while `armed` restarts the event: `cnt_q` goes to 0 and the idle count restarts. A data-valid in the trigger cycle is not written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| snoop_data | input | DATA_W | Snooped readout word |
| snoop_dv_n | input | 1 | Active-low data-valid of the snooped stream |
| cap_trig | input | 1 | Capture trigger |
| cap_en | input | 1 | Control-register enable for the trigger |
| cnt_ld | input | 1 | Load strobe for the address counter |
| cnt_ld_val | input | ADDR_W | Value to load into the counter |
| cnt_q | output | ADDR_W | Current address counter |
| rd_req | input | 1 | Data-read request, one cycle |
| rd_valid | output | 1 | Read data valid, one cycle |
| rd_data | output | DATA_W | Read data word |
| armed | output | 1 | 1 while capturing, 0 once the event is complete |

## Verification
The assertions assume the following about the inputs:
- Each data-valid low lasts one cycle for each word.
- Software issues at most one outstanding read.
- A counter load does not coincide with an accepted trigger unless the trigger is meant to win.

The stimulus keeps to these assumptions. It drives every data-valid pulse for exactly one cycle. It waits for `rd_valid` before the next read, and it places loads only in cycles without a write, except in the deliberate trigger-versus-write case. The assertions also rely on `IDLE_CYCLES` being at least 2, so that the idle counter can tell the arming cycle apart from the timeout.

// File: rtl/evmon_capture.sv
module evmon_capture #(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 8,
  parameter int IDLE_CYCLES = 125
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] snoop_data,
  input  logic              snoop_dv_n,
  input  logic              cap_trig,
  input  logic              cap_en,
  input  logic              cnt_ld,
  input  logic [ADDR_W-1:0] cnt_ld_val,
  output logic [ADDR_W-1:0] cnt_q,
  input  logic              rd_req,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              armed
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int TW    = $clog2(IDLE_CYCLES + 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [TW-1:0]     idle_q;
  logic              rd_pend_q;

  wire start   = cap_trig & cap_en;
  wire wr_en   = armed & ~snoop_dv_n & ~start;
  wire rd_go   = (rd_req | rd_pend_q) & ~wr_en;
  wire timeout = armed & ~wr_en & ~start & (idle_q == TW'(IDLE_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt_q <= '0;
    else if (start)            cnt_q <= '0;
    else if (cnt_ld)           cnt_q <= cnt_ld_val;
    else if (wr_en || rd_go)   cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        armed <= 1'b0;
    else if (start)    armed <= 1'b1;
    else if (timeout)  armed <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)               idle_q <= '0;
    else if (start || wr_en)  idle_q <= '0;
    else if (armed)           idle_q <= idle_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_pend_q <= 1'b0;
      rd_valid  <= 1'b0;
    end else begin
      rd_valid <= rd_go;
      if (rd_go)       rd_pend_q <= 1'b0;
      else if (rd_req) rd_pend_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en)      mem[cnt_q] <= snoop_data;
    else if (rd_go) rd_data    <= mem[cnt_q];
  end
endmodule

// File: rtl/evmon_capture_chk.sv
module evmon_capture_chk #(
  parameter int ADDR_W      = 8,
  parameter int IDLE_CYCLES = 125
) (
  input logic                               clk,
  input logic                               rst_n,
  input logic                               cap_trig,
  input logic                               cap_en,
  input logic                               cnt_ld,
  input logic [ADDR_W-1:0]                  cnt_ld_val,
  input logic [ADDR_W-1:0]                  cnt_q,
  input logic                               rd_valid,
  input logic                               armed,
  input logic                               wr_en,
  input logic                               rd_go,
  input logic [$clog2(IDLE_CYCLES+1)-1:0]   idle_q
);
  // R2
  start_arms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_trig && cap_en |=> armed && cnt_q == '0);
  // R2
  en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !armed && cap_trig && !cap_en |=> !armed);
  // R3
  wr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !cnt_ld |=> cnt_q == ADDR_W'($past(cnt_q) + 1'b1));
  // R4
  idle_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> idle_q < IDLE_CYCLES);
  // R4
  stay_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !armed && !(cap_trig && cap_en) |=> !armed);
  // R4
  no_wr_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> !wr_en);
  // R5
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_ld && !(cap_trig && cap_en) |=> cnt_q == $past(cnt_ld_val));
  // R6
  rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go |=> rd_valid);
  // R6
  rd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go && !cnt_ld && !(cap_trig && cap_en) |=> cnt_q == ADDR_W'($past(cnt_q) + 1'b1));
  // R7
  wr_blocks_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !rd_valid);
endmodule

bind evmon_capture evmon_capture_chk #(.ADDR_W(ADDR_W), .IDLE_CYCLES(IDLE_CYCLES)) chk_i (
  .clk(clk), .rst_n(rst_n), .cap_trig(cap_trig), .cap_en(cap_en),
  .cnt_ld(cnt_ld), .cnt_ld_val(cnt_ld_val), .cnt_q(cnt_q),
  .rd_valid(rd_valid), .armed(armed), .wr_en(wr_en), .rd_go(rd_go),
  .idle_q(idle_q)
);

// File: tb/evmon_capture_tb_top.sv
module evmon_capture_tb_top;
  localparam int IDLE = 125;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] snoop_data = '0;
  logic        snoop_dv_n = 1'b1;
  logic        cap_trig = 1'b0, cap_en = 1'b0, cnt_ld = 1'b0, rd_req = 1'b0;
  logic [7:0]  cnt_ld_val = '0;
  logic [7:0]  cnt_q;
  logic        rd_valid, armed;
  logic [15:0] rd_data;
  logic [15:0] model [256];
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  evmon_capture #(.IDLE_CYCLES(IDLE)) dut_i (
    .clk(clk), .rst_n(rst_n), .snoop_data(snoop_data), .snoop_dv_n(snoop_dv_n),
    .cap_trig(cap_trig), .cap_en(cap_en), .cnt_ld(cnt_ld), .cnt_ld_val(cnt_ld_val),
    .cnt_q(cnt_q), .rd_req(rd_req), .rd_valid(rd_valid), .rd_data(rd_data),
    .armed(armed));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [15:0] w);
    snoop_data = w; snoop_dv_n = 1'b0;
    @(negedge clk); snoop_dv_n = 1'b1;
  endtask

  task automatic load(input logic [7:0] a);
    cnt_ld = 1'b1; cnt_ld_val = a;
    @(negedge clk); cnt_ld = 1'b0;
  endtask

  task automatic trig(input logic en);
    cap_en = en; cap_trig = 1'b1;
    @(negedge clk); cap_trig = 1'b0;
  endtask

  task automatic rd_word(output logic [15:0] d, output logic v);
    rd_req = 1'b1;
    @(negedge clk); rd_req = 1'b0;
    v = rd_valid; d = rd_data;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (armed && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic t_reset();
    chk("R1 cnt", cnt_q, 0);
    chk("R1 armed", armed, 0);
    chk("R1 rd_valid", rd_valid, 0);
  endtask

  task automatic t_gate();
    load(8'd5);
    trig(1'b0);
    chk("R2 disabled trig armed", armed, 0);
    chk("R2 disabled trig cnt", cnt_q, 5);
    push(16'hdead);
    chk("R4 unarmed write cnt", cnt_q, 5);
  endtask

  task automatic t_capture();
    int n;
    trig(1'b1);
    chk("R2 armed", armed, 1);
    chk("R2 cnt cleared", cnt_q, 0);
    for (int i = 0; i < 10; i++) begin
      if (i != 0) repeat (3) @(negedge clk);
      push(16'h1000 + 16'(i * 7));
      model[i] = 16'h1000 + 16'(i * 7);
    end
    chk("R3 cnt after 10 writes", cnt_q, 10);
    wait_idle(n);
    chk("R4 idle length", n, IDLE);
    push(16'hbeef);
    chk("R4 locked cnt", cnt_q, 10);
  endtask

  task automatic t_readback();
    logic [15:0] d; logic v;
    load(8'd0);
    chk("R5 cnt loaded", cnt_q, 0);
    for (int i = 0; i < 10; i++) begin
      rd_word(d, v);
      chk("R6 valid", v, 1);
      chk("R6 data", d, model[i]);
      chk("R6 cnt step", cnt_q, i + 1);
    end
    @(negedge clk);
    chk("R6 valid one cycle", rd_valid, 0);
    chk("R4 locked word kept", model[9], 16'h1000 + 63);
  endtask

  task automatic t_reread();
    logic [15:0] d; logic v;
    load(8'd3);
    rd_word(d, v);
    chk("R8 first read", d, model[3]);
    load(8'd3);
    rd_word(d, v);
    chk("R8 second read", d, model[3]);
    chk("R8 cnt", cnt_q, 4);
  endtask

  task automatic t_conflict();
    logic [15:0] d; logic v; int n;
    trig(1'b1);
    for (int i = 0; i < 5; i++) begin
      push(16'h2000 + 16'(i));
      model[i] = 16'h2000 + 16'(i);
    end
    load(8'd2);
    snoop_data = 16'h2abc; snoop_dv_n = 1'b0; rd_req = 1'b1;
    @(negedge clk);
    snoop_dv_n = 1'b1; rd_req = 1'b0;
    model[2] = 16'h2abc;
    chk("R7 read stalled", rd_valid, 0);
    chk("R7 cnt after write", cnt_q, 3);
    @(negedge clk);
    chk("R7 read served", rd_valid, 1);
    chk("R7 read data", rd_data, model[3]);
    chk("R7 cnt after read", cnt_q, 4);
    wait_idle(n);
    load(8'd2);
    rd_word(d, v);
    chk("R7 write landed", d, 16'h2abc);
  endtask

  task automatic t_restart();
    logic [15:0] d; logic v; int n;
    trig(1'b1);
    push(16'h3111); model[0] = 16'h3111;
    push(16'h3222); model[1] = 16'h3222;
    chk("R10 cnt before restart", cnt_q, 2);
    cap_en = 1'b1; cap_trig = 1'b1; snoop_data = 16'h3fff; snoop_dv_n = 1'b0;
    @(negedge clk);
    cap_trig = 1'b0; snoop_dv_n = 1'b1;
    chk("R10 armed", armed, 1);
    chk("R10 cnt restart", cnt_q, 0);
    wait_idle(n);
    chk("R10 idle restarted", n, IDLE);
    load(8'd0);
    rd_word(d, v);
    chk("R10 trigger beat write", d, model[0]);
  endtask

  task automatic t_wrap();
    logic [15:0] d; logic v; int n;
    trig(1'b1);
    load(8'd254);
    push(16'h4a01); model[254] = 16'h4a01;
    push(16'h4a02); model[255] = 16'h4a02;
    push(16'h4a03); model[0]   = 16'h4a03;
    chk("R9 write wrap cnt", cnt_q, 1);
    wait_idle(n);
    load(8'd254);
    rd_word(d, v); chk("R9 read 254", d, model[254]);
    rd_word(d, v); chk("R9 read 255", d, model[255]);
    chk("R9 read wrap cnt", cnt_q, 0);
    rd_word(d, v); chk("R9 read 0", d, model[0]);
    chk("R9 cnt end", cnt_q, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_gate();
    t_capture();
    t_readback();
    t_reread();
    t_conflict();
    t_restart();
    t_wrap();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule